// File: doc/BRIEF.md
# Shift-Rotate Unit with Carry

This block is a purely combinational shift and rotate datapath for a 16-bit word. A 3-bit operation code selects one of eight operations. Four are shifts: logical left, logical right, arithmetic left and arithmetic right. Four are rotates: a plain rotate left or right inside the word, and a rotate left or right through a carry bit. The amount input gives how many positions the word moves, from 0 to 15. Besides the moved word, the block produces a carry output.

Internally every operation becomes a left move of a 17-bit vector. That vector holds the carry in its top position and the data below it. Right-going operations reverse the bit order before the move and again after it. The move itself is a logarithmic chain with one stage per amount bit. In a stage, the operation decides what refills the vacated low positions: zeros, copies of the sign bit, bits wrapped around the word, or bits wrapped around the 17-bit ring. The top position of the vector always ends up holding the carry output.

There are no states, clocks or registers. The outputs follow the inputs within one combinational settling time. The width is a parameter, and the amount width is derived from it.

Top module: `shift_rotate_unit`

## Requirements
- R1: Operation code bit 0 selects the direction (0 left, 1 right). The codes are 000 logical left, 001 logical right, 010 arithmetic left, 011 arithmetic right, 100 rotate left, 101 rotate right, 110 rotate left through carry, 111 rotate right through carry.
- R2: Logical shift left (000) moves the word up by the amount and fills zeros at the bottom. For an amount n > 0, the carry output is input bit 16-n.
- R3: Logical shift right (001) moves the word down by the amount and fills zeros at the top. For an amount n > 0, the carry output is input bit n-1.
- R4: Arithmetic shift left (010) gives exactly the same result and carry as logical shift left.
- R5: Arithmetic shift right (011) fills the vacated upper bits with copies of input bit 15. For n > 0, the carry output is input bit n-1.
- R6: Rotate left and rotate right (100, 101) move the bits around the 16-bit word. For n > 0, the carry output is the last bit carried across the word edge: result bit 0 for left and result bit 15 for right.
- R7: Rotate through carry (110, 111) rotates the 17-bit ring formed by the carry input above bit 15. The bit that lands in the carry position is the carry output.
- R8: With an amount of zero, the result equals the input word and the carry output equals the carry input, for every operation code.
- R9: For codes 000 to 101 with an amount above zero, the carry input has no effect on the result or on the carry output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | 16 | Word to be shifted or rotated |
| amount | input | 4 | Number of positions to move, unsigned |
| op_code | input | 3 | Operation select (see R1) |
| carry_in | input | 1 | Carry input, part of the ring for 110/111 |
| data_out | output | 16 | Shifted or rotated word |
| carry_out | output | 1 | Carry output |

## Verification
The bench builds the block with its default width of 16, which gives a 4-bit amount and a four-stage chain. At that size every amount from 0 to 15 can be swept under every operation code, for a set of corner words and both carry values. This reaches the full-width moves, where the carry comes from bit 0 or bit 15, and the zero-amount bypass. Random vectors from a fixed seed are then compared against a bench model that moves the word one bit at a time. Together these cover the mixes of stage enables and refill modes.

// File: rtl/sru_pkg.sv
package sru_pkg;

    typedef enum logic [2:0] {
        OP_SHL = 3'b000,
        OP_SHR = 3'b001,
        OP_SAL = 3'b010,
        OP_SAR = 3'b011,
        OP_ROL = 3'b100,
        OP_ROR = 3'b101,
        OP_RCL = 3'b110,
        OP_RCR = 3'b111
    } sru_op_e;

    typedef enum logic [1:0] {
        FILL_ZERO = 2'd0,
        FILL_SIGN = 2'd1,
        FILL_WORD = 2'd2,
        FILL_RING = 2'd3
    } sru_fill_e;

endpackage

// File: rtl/sru_decode.sv
module sru_decode
    import sru_pkg::*;
(
    input  logic [2:0] op_code,
    output logic       dir_right,
    output sru_fill_e  fill_kind
);

    sru_op_e op_e;

    always_comb begin
        op_e      = sru_op_e'(op_code);
        dir_right = 1'b0;
        fill_kind = FILL_ZERO;
        unique case (op_e)
            OP_SHL: begin dir_right = 1'b0; fill_kind = FILL_ZERO; end
            OP_SHR: begin dir_right = 1'b1; fill_kind = FILL_ZERO; end
            OP_SAL: begin dir_right = 1'b0; fill_kind = FILL_ZERO; end
            OP_SAR: begin dir_right = 1'b1; fill_kind = FILL_SIGN; end
            OP_ROL: begin dir_right = 1'b0; fill_kind = FILL_WORD; end
            OP_ROR: begin dir_right = 1'b1; fill_kind = FILL_WORD; end
            OP_RCL: begin dir_right = 1'b0; fill_kind = FILL_RING; end
            OP_RCR: begin dir_right = 1'b1; fill_kind = FILL_RING; end
            default: begin dir_right = 1'b0; fill_kind = FILL_ZERO; end
        endcase
    end

    // R1: the direction follows bit 0, and wrap refills belong to the rotate codes only
    always_comb begin
        assert_dir_bit0_R1: assert (dir_right == op_code[0]);
        assert_wrap_only_rotate_R1: assert (!(fill_kind inside {FILL_WORD, FILL_RING}) || op_code[2]);
        assert_sign_only_sar_R5: assert ((fill_kind != FILL_SIGN) || (op_code == 3'b011));
    end

endmodule

// File: rtl/sru_orient.sv
module sru_orient #(
    parameter int W = 16
) (
    input  logic         flip,
    input  logic [W-1:0] word_in,
    output logic [W-1:0] word_out
);

    logic [W-1:0] reversed;

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign reversed[i] = word_in[W-1-i];
    end

    assign word_out = flip ? reversed : word_in;

endmodule

// File: rtl/sru_stage.sv
module sru_stage
    import sru_pkg::*;
#(
    parameter int W = 16,
    parameter int K = 1
) (
    input  logic       en,
    input  sru_fill_e  fill_kind,
    input  logic       sign_bit,
    input  logic [W:0] x,
    output logic [W:0] y
);

    logic [K-1:0] refill;

    always_comb begin
        unique case (fill_kind)
            FILL_ZERO: refill = '0;
            FILL_SIGN: refill = {K{sign_bit}};
            FILL_WORD: refill = x[W-1:W-K];
            FILL_RING: refill = x[W:W-K+1];
            default:   refill = '0;
        endcase
    end

    always_comb begin
        if (en) begin
            y = {x[W-K], x[W-1-K:0], refill};
        end else begin
            y = x;
        end
    end

    // R7: a ring stage keeps the number of ones in the 17-bit vector
    always_comb begin
        assert_ring_stage_count_R7: assert ((fill_kind != FILL_RING) || ($countones(y) == $countones(x)));
    end

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
    import sru_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] data_in,
    input  logic [AMT_W-1:0] amount,
    input  logic [2:0]       op_code,
    input  logic             carry_in,
    output logic [WIDTH-1:0] data_out,
    output logic             carry_out
);

    logic             dir_right;
    sru_fill_e        fill_kind;
    logic [WIDTH-1:0] oriented_in;
    logic [WIDTH:0]   chain [AMT_W+1];

    sru_decode u_decode (
        .op_code   (op_code),
        .dir_right (dir_right),
        .fill_kind (fill_kind)
    );

    sru_orient #(.W(WIDTH)) u_orient_in (
        .flip     (dir_right),
        .word_in  (data_in),
        .word_out (oriented_in)
    );

    assign chain[0] = {carry_in, oriented_in};

    for (genvar g = 0; g < AMT_W; g++) begin : g_stage
        sru_stage #(.W(WIDTH), .K(1 << g)) u_stage (
            .en        (amount[g]),
            .fill_kind (fill_kind),
            .sign_bit  (data_in[WIDTH-1]),
            .x         (chain[g]),
            .y         (chain[g+1])
        );
    end

    sru_orient #(.W(WIDTH)) u_orient_out (
        .flip     (dir_right),
        .word_in  (chain[AMT_W][WIDTH-1:0]),
        .word_out (data_out)
    );

    assign carry_out = chain[AMT_W][WIDTH];

    // port-level checks on the complete datapath
    always_comb begin
        assert_zero_amt_passthru_R8: assert ((amount != '0) || (data_out == data_in && carry_out == carry_in));
        assert_shl_low_clear_R2: assert (!((op_code == 3'b000 || op_code == 3'b010) && amount != '0) || !data_out[0]);
        assert_shr_high_clear_R3: assert (!(op_code == 3'b001 && amount != '0) || !data_out[WIDTH-1]);
        assert_sar_keeps_sign_R5: assert ((op_code != 3'b011) || (data_out[WIDTH-1] == data_in[WIDTH-1]));
        assert_rot_count_R6: assert (!(op_code == 3'b100 || op_code == 3'b101) || ($countones(data_out) == $countones(data_in)));
        assert_ring_count_R7: assert (!(op_code == 3'b110 || op_code == 3'b111) || ($countones({carry_out, data_out}) == $countones({carry_in, data_in})));
    end

endmodule

// File: tb/shift_rotate_unit_tb.sv
module shift_rotate_unit_tb;

    logic        clk = 1'b0;
    logic [15:0] d;
    logic [3:0]  amt;
    logic [2:0]  op;
    logic        cin;
    logic [15:0] res;
    logic        cout;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    shift_rotate_unit u_dut (
        .data_in   (d),
        .amount    (amt),
        .op_code   (op),
        .carry_in  (cin),
        .data_out  (res),
        .carry_out (cout)
    );

    function automatic logic [16:0] model(input logic [15:0] w, input int n,
                                          input logic [2:0] code, input logic c);
        logic [15:0] v = w;
        logic        k = c;
        logic        t;
        for (int i = 0; i < n; i++) begin
            case (code)
                3'b000, 3'b010: begin k = v[15]; v = {v[14:0], 1'b0}; end
                3'b001:         begin k = v[0];  v = {1'b0, v[15:1]}; end
                3'b011:         begin k = v[0];  v = {v[15], v[15:1]}; end
                3'b100:         begin k = v[15]; v = {v[14:0], v[15]}; end
                3'b101:         begin k = v[0];  v = {v[0], v[15:1]}; end
                3'b110:         begin t = v[15]; v = {v[14:0], k}; k = t; end
                default:        begin t = v[0];  v = {k, v[15:1]}; k = t; end
            endcase
        end
        return {k, v};
    endfunction

    function automatic string tag_of(input logic [2:0] code, input int n);
        if (n == 0) return "R8";
        case (code)
            3'b000: return "R2";
            3'b001: return "R3";
            3'b010: return "R4";
            3'b011: return "R5";
            3'b100, 3'b101: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [16:0] act, input logic [16:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] w, input int n, input logic [2:0] code, input logic c);
        @(negedge clk);
        d = w; amt = n[3:0]; op = code; cin = c;
        #2;
    endtask

    task automatic run_vec(input logic [15:0] w, input int n, input logic [2:0] code, input logic c);
        logic [16:0] exp;
        drive(w, n, code, c);
        exp = model(w, n, code, c);
        check({cout, res} == exp, tag_of(code, n), {cout, res}, exp);
    endtask

    task automatic fixed(input logic [2:0] code, input logic [15:0] er, input logic ec);
        drive(16'hB2C5, 2, code, 1'b0);
        check({cout, res} == {ec, er}, "R1", {cout, res}, {ec, er});
    endtask

    initial begin
        logic [15:0] corners [6];
        corners[0] = 16'h0000; corners[1] = 16'hFFFF; corners[2] = 16'h8000;
        corners[3] = 16'h0001; corners[4] = 16'hA5C3; corners[5] = 16'h7FFE;
        void'($urandom(32'd2718));

        // R8 at the first inputs applied
        drive(16'h1234, 0, 3'b000, 1'b1);
        check(res == 16'h1234 && cout == 1'b1, "R8", {cout, res}, {1'b1, 16'h1234});

        // R1: code map on a fixed word, amount 2, carry in 0
        fixed(3'b000, 16'hCB14, 1'b0);
        fixed(3'b010, 16'hCB14, 1'b0);
        fixed(3'b100, 16'hCB16, 1'b0);
        fixed(3'b110, 16'hCB15, 1'b0);
        fixed(3'b001, 16'h2CB1, 1'b0);
        fixed(3'b011, 16'hECB1, 1'b0);
        fixed(3'b101, 16'h6CB1, 1'b0);
        fixed(3'b111, 16'hACB1, 1'b0);

        // R2..R8: full sweep of amounts and codes over corner words and both carries
        for (int wi = 0; wi < 6; wi++)
            for (int n = 0; n < 16; n++)
                for (int code = 0; code < 8; code++)
                    for (int c = 0; c < 2; c++)
                        run_vec(corners[wi], n, code[2:0], c[0]);

        // R9: the carry input leaves non-ring operations untouched for n > 0
        for (int i = 0; i < 200; i++) begin
            logic [15:0] w = 16'($urandom);
            int          n = 1 + int'($urandom % 15);
            logic [2:0]  code = 3'($urandom % 6);
            logic [16:0] a0;
            drive(w, n, code, 1'b0);
            a0 = {cout, res};
            drive(w, n, code, 1'b1);
            check({cout, res} == a0, "R9", {cout, res}, a0);
        end

        // random vectors against the bit-serial model
        for (int i = 0; i < 3000; i++)
            run_vec(16'($urandom), int'($urandom % 16), 3'($urandom), 1'($urandom));

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule